// File: doc/BRIEF.md
# Link Frame Serialiser with Comma Fill and CRC

This block feeds one high-speed serial link. Once per bunch crossing it accepts a 128-bit payload. It then writes an eight-word frame of 16-bit words into a small dual-clock buffer, one word per fast clock cycle. The fast clock runs at eight times the crossing rate, so one frame fills exactly one crossing. The transmitter side reads the buffer in its own clock domain. With each word it gets a flag that marks the word as a control character for the downstream 8b/10b encoder.

Seven frame slots carry data and the eighth carries a 16-bit CRC computed over those seven words. Sparse events are common, so a data slot whose word is zero is sent as a comma control character and not as a literal zero. The buffer uses Gray-coded pointers across the clock boundary. It reports a read issued while it is empty.

Top module: `link_frame_serialiser`

## Requirements
- R1: A load strobe sampled while the serialiser is idle, or during the eighth slot of a frame, captures the payload on that edge. The slots of a new frame then follow on the next eight serialiser clock edges, one buffer write per edge.
- R2: Slot s (s = 0 to 6) carries payload bits [16s+15:16s]. Slot 7 carries the CRC. Words are read out in slot order.
- R3: Payload bits [127:112] are reserved and have no effect on any output word or flag.
- R4: A data slot whose 16-bit word is zero is sent as 16'hBCBC (a K28.5 code in each byte) with the K flag at 1. Every non-zero data word and every CRC word has the K flag at 0.
- R5: The CRC uses polynomial 0x1021 and seed 0xFFFF. It takes data bits most significant first and applies no final inversion. It covers the seven data words, and comma-filled slots count as zero.
- R6: A load strobe sampled during slots 0 to 6 of an active frame is ignored. It adds no words and does not alter the frame in progress.
- R7: When a load is accepted in slot 7, the next frame follows with no gap. Its CRC restarts from the seed.
- R8: When both clocks are the same, the first word of a frame can be read by a read request sampled on the fourth transmit clock edge after the load edge. A request on the third edge finds the buffer empty. Read data appears on the outputs after the edge that accepts the read.
- R9: A read request while the buffer is empty raises the underflow output for exactly that one cycle. It leaves the output word and flag unchanged and consumes nothing.
- R10: After reset the output word, the K flag and the underflow output are all 0.
- R11: The 16-entry buffer holds two complete back-to-back frames without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| serClk | input | 1 | Serialiser clock, eight times the crossing rate |
| serRstN | input | 1 | Active-low reset, serialiser domain |
| bcLoad | input | 1 | Crossing strobe; payloadIn is valid while it is high |
| payloadIn | input | 128 | Crossing payload; the top 16 bits are reserved |
| txClk | input | 1 | Transmit-side clock |
| txRstN | input | 1 | Active-low reset, transmit domain |
| txRead | input | 1 | Read request for one word |
| txWord | output | 16 | Word most recently read |
| txIsK | output | 1 | Marks txWord as a control character |
| txUnderflow | output | 1 | High for one cycle after a read of an empty buffer |

## Verification
The first word becomes readable after three transmit edges: one edge to write the word and two to synchronise the pointer. A read on the fourth edge after the load therefore succeeds, and a read on the third edge underflows. Each read's result is sampled on the falling edge after the accepting rising edge. The other frame checks wait a fixed margin of more than eight edges after the load before reading, so every slot has been written before the reads begin. Ignored mid-frame loads are checked with a ninth read, which must underflow.

// File: rtl/frame_pkg.sv
package frame_pkg;
  localparam int WORD_W     = 16;
  localparam int SLOTS      = 8;
  localparam int DATA_SLOTS = SLOTS - 1;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int PAYLOAD_W  = WORD_W * SLOTS;
  localparam int DATA_W     = WORD_W * DATA_SLOTS;
  localparam logic [WORD_W-1:0] COMMA_WORD = 16'hBCBC;
  localparam logic [WORD_W-1:0] CRC_SEED   = 16'hFFFF;
  localparam logic [WORD_W-1:0] CRC_POLY   = 16'h1021;

  typedef struct packed {
    logic              load;
    logic              emit;
    logic              last;
    logic [SLOT_W-1:0] slot;
  } ser_strobe_t;
endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bcLoad,
  output ser_strobe_t strb
);
  logic              active;
  logic [SLOT_W-1:0] slot;
  logic              lastSlot;
  logic              accept;

  assign lastSlot = active && (slot == SLOT_W'(SLOTS - 1));
  assign accept   = bcLoad && (!active || lastSlot);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      slot   <= '0;
    end else if (accept) begin
      active <= 1'b1;
      slot   <= '0;
    end else if (lastSlot) begin
      active <= 1'b0;
      slot   <= '0;
    end else if (active) begin
      slot <= slot + 1'b1;
    end
  end

  always_comb begin
    strb.load = accept;
    strb.emit = active;
    strb.last = lastSlot;
    strb.slot = slot;
  end
endmodule

// File: rtl/frame_datapath.sv
module frame_datapath
  import frame_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ser_strobe_t       strb,
  input  logic [DATA_W-1:0] payload,
  output logic              wrEn,
  output logic [WORD_W:0]   wrData
);
  logic [DATA_W-1:0] payloadReg;
  logic [WORD_W-1:0] crcReg;
  logic [WORD_W-1:0] wordArr [SLOTS];
  logic [WORD_W-1:0] dataWord;
  logic              isZero;

  function automatic logic [WORD_W-1:0] crcStep(input logic [WORD_W-1:0] c,
                                                input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    logic fb;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = r[WORD_W-1] ^ d[i];
      r  = {r[WORD_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < DATA_SLOTS) begin : g_data
      assign wordArr[g] = payloadReg[g*WORD_W +: WORD_W];
    end else begin : g_crc
      assign wordArr[g] = '0;
    end
  end

  assign dataWord = wordArr[strb.slot];
  assign isZero   = (dataWord == '0);
  assign wrEn     = strb.emit;

  always_comb begin
    if (strb.last)  wrData = {1'b0, crcReg};
    else if (isZero) wrData = {1'b1, COMMA_WORD};
    else             wrData = {1'b0, dataWord};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      payloadReg <= '0;
      crcReg     <= CRC_SEED;
    end else begin
      if (strb.load) payloadReg <= payload;
      if (strb.emit) crcReg <= strb.last ? CRC_SEED : crcStep(crcReg, dataWord);
    end
  end
endmodule

// File: rtl/gray_fifo.sv
module gray_fifo #(
  parameter int DW = 17,
  parameter int AW = 4
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  output logic          full,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          rdEn,
  output logic [DW-1:0] rdData,
  output logic          underflow
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wrBin, wrGray, rdBin, rdGray;
  logic [AW:0] rdGrayS1, rdGrayS2, wrGrayS1, wrGrayS2;
  logic [AW:0] wrBinNext, rdBinNext;
  logic        empty;

  assign wrBinNext = wrBin + 1'b1;
  assign rdBinNext = rdBin + 1'b1;
  assign full  = (wrGray == {~rdGrayS2[AW:AW-1], rdGrayS2[AW-2:0]});
  assign empty = (rdGray == wrGrayS2);

  always_ff @(posedge wrClk) begin
    if (wrEn) mem[wrBin[AW-1:0]] <= wrData;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      rdGrayS1 <= '0;
      rdGrayS2 <= '0;
    end else begin
      rdGrayS1 <= rdGray;
      rdGrayS2 <= rdGrayS1;
      if (wrEn) begin
        wrBin  <= wrBinNext;
        wrGray <= wrBinNext ^ (wrBinNext >> 1);
      end
    end
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin     <= '0;
      rdGray    <= '0;
      wrGrayS1  <= '0;
      wrGrayS2  <= '0;
      rdData    <= '0;
      underflow <= 1'b0;
    end else begin
      wrGrayS1  <= wrGray;
      wrGrayS2  <= wrGrayS1;
      underflow <= rdEn && empty;
      if (rdEn && !empty) begin
        rdData <= mem[rdBin[AW-1:0]];
        rdBin  <= rdBinNext;
        rdGray <= rdBinNext ^ (rdBinNext >> 1);
      end
    end
  end
endmodule

// File: rtl/link_frame_serialiser.sv
module link_frame_serialiser
  import frame_pkg::*;
#(
  parameter int FIFO_AW = 4
) (
  input  logic                 serClk,
  input  logic                 serRstN,
  input  logic                 bcLoad,
  input  logic [PAYLOAD_W-1:0] payloadIn,
  input  logic                 txClk,
  input  logic                 txRstN,
  input  logic                 txRead,
  output logic [WORD_W-1:0]    txWord,
  output logic                 txIsK,
  output logic                 txUnderflow
);
  ser_strobe_t     strb;
  logic            fifoWrEn;
  logic [WORD_W:0] fifoWrData;
  logic            fifoFull;
  logic [WORD_W:0] fifoRdData;

  frame_ctrl i_ctrl (
    .clk(serClk), .rstN(serRstN), .bcLoad(bcLoad), .strb(strb)
  );

  frame_datapath i_dp (
    .clk(serClk), .rstN(serRstN), .strb(strb),
    .payload(payloadIn[DATA_W-1:0]),
    .wrEn(fifoWrEn), .wrData(fifoWrData)
  );

  gray_fifo #(.DW(WORD_W + 1), .AW(FIFO_AW)) i_fifo (
    .wrClk(serClk), .wrRstN(serRstN), .wrEn(fifoWrEn), .wrData(fifoWrData),
    .full(fifoFull),
    .rdClk(txClk), .rdRstN(txRstN), .rdEn(txRead), .rdData(fifoRdData),
    .underflow(txUnderflow)
  );

  assign txWord = fifoRdData[WORD_W-1:0];
  assign txIsK  = fifoRdData[WORD_W];
endmodule

// File: rtl/link_frame_serialiser_chk.sv
module link_frame_serialiser_chk
  import frame_pkg::*;
(
  input logic              serClk,
  input logic              serRstN,
  input logic              bcLoad,
  input logic              txClk,
  input logic              txRstN,
  input logic              txRead,
  input logic [WORD_W-1:0] txWord,
  input logic              txIsK,
  input logic              txUnderflow,
  input ser_strobe_t       strb,
  input logic              fifoWrEn,
  input logic              fifoFull
);
  AST_KFLAG_COMMA: assert property (@(posedge txClk) disable iff (!txRstN)
    txIsK |-> txWord == COMMA_WORD); // R4

  AST_NO_OVERFLOW: assert property (@(posedge serClk) disable iff (!serRstN)
    fifoWrEn |-> !fifoFull); // R11

  AST_FRAME_START: assert property (@(posedge serClk) disable iff (!serRstN)
    (bcLoad && !strb.emit) |=> (strb.emit && strb.slot == '0)); // R1

  AST_MIDFRAME_IGNORED: assert property (@(posedge serClk) disable iff (!serRstN)
    (strb.emit && !strb.last) |=> (strb.emit && strb.slot == $past(strb.slot) + 1'b1)); // R6

  AST_UNDERFLOW_PULSE: assert property (@(posedge txClk) disable iff (!txRstN)
    $rose(txUnderflow) |-> $stable(txWord) && $stable(txIsK)); // R9
endmodule

bind link_frame_serialiser link_frame_serialiser_chk i_chk (
  .serClk(serClk), .serRstN(serRstN), .bcLoad(bcLoad),
  .txClk(txClk), .txRstN(txRstN), .txRead(txRead),
  .txWord(txWord), .txIsK(txIsK), .txUnderflow(txUnderflow),
  .strb(strb), .fifoWrEn(fifoWrEn), .fifoFull(fifoFull)
);

// File: tb/test_link_frame_serialiser.sv
`timescale 1ns/1ps
module test_link_frame_serialiser;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         bcLoad = 1'b0;
  logic [127:0] payloadIn = '0;
  logic         txRead = 1'b0;
  logic [15:0]  txWord;
  logic         txIsK;
  logic         txUnderflow;
  int           nRun = 0;
  int           nFail = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  link_frame_serialiser i_link_frame_serialiser (
    .serClk(clk), .serRstN(rstN), .bcLoad(bcLoad), .payloadIn(payloadIn),
    .txClk(clk), .txRstN(rstN), .txRead(txRead),
    .txWord(txWord), .txIsK(txIsK), .txUnderflow(txUnderflow)
  );

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    for (int i = 15; i >= 0; i--) begin
      logic fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  function automatic logic [16:0] expWord(input logic [127:0] p, input int s);
    logic [15:0] c = 16'hFFFF;
    if (s == 7) begin
      for (int k = 0; k < 7; k++) c = crcStep(c, p[16*k +: 16]);
      return {1'b0, c};
    end
    if (p[16*s +: 16] == 16'h0000) return {1'b1, 16'hBCBC};
    return {1'b0, p[16*s +: 16]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadFrame(input logic [127:0] p);
    @(negedge clk); bcLoad = 1'b1; payloadIn = p;
    @(negedge clk); bcLoad = 1'b0;
  endtask

  task automatic readWord(input string req, input logic [127:0] p, input int s);
    logic [16:0] e = expWord(p, s);
    txRead = 1'b1;
    @(negedge clk); txRead = 1'b0;
    check(req, {15'd0, txIsK, txWord}, {15'd0, e});
    check(req, {31'd0, txUnderflow}, 32'd0);
  endtask

  task automatic readFrame(input string req, input logic [127:0] p);
    for (int s = 0; s < 8; s++) readWord(req, p, s);
  endtask

  task automatic readEmpty(input string req);
    logic [16:0] prev = {txIsK, txWord};
    txRead = 1'b1;
    @(negedge clk); txRead = 1'b0;
    check(req, {31'd0, txUnderflow}, 32'd1);
    check(req, {15'd0, txIsK, txWord}, {15'd0, prev});
    @(negedge clk);
    check(req, {31'd0, txUnderflow}, 32'd0);
  endtask

  task automatic testReset();
    check("R10", {15'd0, txIsK, txWord}, 32'd0);
    check("R10", {31'd0, txUnderflow}, 32'd0);
  endtask

  task automatic testDense();
    logic [127:0] p = 128'h0000_7777_6666_5555_4444_3333_2222_1111;
    loadFrame(p); repeat (12) @(negedge clk);
    readFrame("R2_R5", p);
  endtask

  task automatic testSparse();
    logic [127:0] p = 128'h0000_0000_A5A5_0000_0000_1234_0000_8001;
    loadFrame(p); repeat (12) @(negedge clk);
    readFrame("R4_R5", p);
    p = '0;
    loadFrame(p); repeat (12) @(negedge clk);
    readFrame("R4", p);
  endtask

  task automatic testReserved();
    logic [127:0] p = 128'hDEAD_0F0F_0000_1357_2468_0000_FFFF_0001;
    loadFrame(p); repeat (12) @(negedge clk);
    readFrame("R3", {16'h0000, p[111:0]});
  endtask

  task automatic testTiming();
    logic [127:0] p = 128'h0000_0707_0606_0505_0404_0303_0202_0101;
    loadFrame(p);
    @(negedge clk); @(negedge clk);
    txRead = 1'b1;
    @(negedge clk);
    check("R8 third edge", {31'd0, txUnderflow}, 32'd1);
    @(negedge clk); txRead = 1'b0;
    check("R8 fourth edge", {15'd0, txIsK, txWord}, {15'd0, expWord(p, 0)});
    check("R8 fourth edge", {31'd0, txUnderflow}, 32'd0);
    for (int s = 1; s < 8; s++) readWord("R8", p, s);
  endtask

  task automatic testMidLoad();
    logic [127:0] a = 128'h0000_00A7_00A6_00A5_00A4_00A3_00A2_00A1;
    logic [127:0] b = 128'h0000_B7B7_B6B6_B5B5_B4B4_B3B3_B2B2_B1B1;
    loadFrame(a);
    @(negedge clk); @(negedge clk);
    loadFrame(b);
    repeat (12) @(negedge clk);
    readFrame("R6", a);
    readEmpty("R6");
  endtask

  task automatic testBackToBack();
    logic [127:0] a = 128'h0000_0000_0000_0000_C004_C003_C002_C001;
    logic [127:0] b = 128'h0000_D007_D006_D005_0000_D003_D002_D001;
    loadFrame(a);
    repeat (6) @(negedge clk);
    loadFrame(b);
    repeat (12) @(negedge clk);
    readFrame("R7_R11", a);
    readFrame("R7_R1", b);
    readEmpty("R11");
  endtask

  task automatic testUnderflow();
    readEmpty("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnderflow();
    testDense();
    testSparse();
    testReserved();
    testTiming();
    testMidLoad();
    testBackToBack();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule